// File: doc/BRIEF.md
# Programmable Beep Tone Generator

This block makes the square-wave beep used for system alert and startup diagnostic signalling. A single 16-bit control word, written and read back through a simple register port, sets a mute flag, a 4-bit volume (attenuation) code and an 8-bit tone factor. The block divides a one-cycle 48 kHz sample strobe by four times the tone factor, so a full tone period spans 4·F strobes. The range runs from 12 kHz at F = 1 down to about 47 Hz at F = 255.

A tone factor of zero turns the internal generator off and passes an external one-bit beep input to the output instead. The attenuation code and mute flag go to a downstream mixer, which does the actual level scaling. While the chip-level reset-state indication is high, the external beep input reaches the output at full level and the mute flag is ignored. This keeps power-on diagnostic beeps audible before any software has configured the block.

Top module: `beep_tone_gen`

## Requirements
- R1: After rst_n is released, the control word reads 8000h (mute on, 0 dB) when MUTE_AT_RESET = 1, and 0000h when it is 0.
- R2: Readback places mute at bit 15, the tone factor F at bits 12:5 and the volume code at bits 4:1. Bits 14:13 and bit 0 always read 0, whatever value was written to them.
- R3: Outside the reset-state indication, atten_code equals the volume field (0000 means 0 dB, 1111 means 45 dB, steps of about 3 dB) and mute_out equals bit 15 of the control word.
- R4: With F nonzero, beep_out toggles on the 2·F-th strobe counted from a restart or from the previous toggle, so one full period is 4·F strobes.
- R5: The divider advances only in cycles where tick_48k is high; in all other cycles the waveform phase is unchanged.
- R6: With F = 0 and the reset-state indication low, beep_out follows ext_beep combinationally and the internal divider stays at zero.
- R7: A write that changes F restarts the divider, and beep_out is low in the following cycle (a strobe in the same cycle is not counted). A write that keeps F unchanged leaves the tone phase undisturbed.
- R8: While in_reset_state is high, beep_out equals ext_beep, atten_code is 0000 and mute_out is 0, whatever the control word holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset of the control word and divider |
| wr_en | input | 1 | Writes wr_data into the control word at the clock edge |
| wr_data | input | 16 | Control word write value |
| rd_data | output | 16 | Control word readback |
| tick_48k | input | 1 | One-cycle 48 kHz sample strobe |
| ext_beep | input | 1 | External beep signal |
| in_reset_state | input | 1 | Chip reset-state indication; forces unattenuated external beep |
| beep_out | output | 1 | Square-wave or bypassed beep bit |
| atten_code | output | 4 | Attenuation code for the mixer |
| mute_out | output | 1 | Mute flag for the mixer |

## Verification
A wrong divider count shows up at beep_out as a toggle that comes one or more strobes early or late. The per-cycle comparison catches this on the first misplaced edge, at most 2·F strobes after the fault. A missed restart on an F change shows up in the very next cycle as a high output, or as a first half-period of the wrong length. Errors in field placement or in the reset-state override show up on rd_data, atten_code or mute_out in the cycle right after the write or the change of the indication.

// File: rtl/beep_tone_gen.sv
module beep_tone_gen #(
  parameter bit MUTE_AT_RESET = 1'b1,
  parameter int FW = 8,
  parameter int PW = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  input  logic        tick_48k,
  input  logic        ext_beep,
  input  logic        in_reset_state,
  output logic        beep_out,
  output logic [3:0]  atten_code,
  output logic        mute_out
);
  localparam int PV_LO = 1;
  localparam int F_LO  = PV_LO + PW;
  localparam int F_HI  = F_LO + FW - 1;
  localparam int CW    = FW + 1;

  logic          mute_q, tone_q;
  logic [FW-1:0] f_q;
  logic [PW-1:0] pv_q;
  logic [CW-1:0] cnt_q;

  wire [FW-1:0] wr_f     = wr_data[F_HI:F_LO];
  wire          f_chg    = wr_en && (wr_f != f_q);
  wire          f_zero   = (f_q == '0);
  wire [CW-1:0] cnt_last = {f_q, 1'b0} - CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mute_q <= MUTE_AT_RESET;
      f_q    <= '0;
      pv_q   <= '0;
      cnt_q  <= '0;
      tone_q <= 1'b0;
    end else begin
      if (wr_en) begin
        mute_q <= wr_data[15];
        f_q    <= wr_f;
        pv_q   <= wr_data[F_LO-1:PV_LO];
      end
      if (f_chg || f_zero) begin
        cnt_q  <= '0;
        tone_q <= 1'b0;
      end else if (tick_48k) begin
        if (cnt_q == cnt_last) begin
          cnt_q  <= '0;
          tone_q <= ~tone_q;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[15] = mute_q;
    rd_data[F_HI:F_LO] = f_q;
    rd_data[F_LO-1:PV_LO] = pv_q;
  end

  assign beep_out   = (in_reset_state || f_zero) ? ext_beep : tone_q;
  assign atten_code = in_reset_state ? 4'd0 : 4'(pv_q);
  assign mute_out   = in_reset_state ? 1'b0 : mute_q;

  p_phase_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_48k && !wr_en) |=> ($stable(cnt_q) && $stable(tone_q)));

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !f_zero |-> (cnt_q < {f_q, 1'b0}));

  p_restart_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    f_chg |=> (cnt_q == '0 && !tone_q));

  p_idle_divider_r6: assert property (@(posedge clk) disable iff (!rst_n)
    f_zero |=> (cnt_q == '0 || $past(wr_en)));

  p_reset_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_reset_state |-> (beep_out == ext_beep && atten_code == 4'd0 && !mute_out));

  p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[14:13] == 2'b00 && !rd_data[0]));
endmodule

// File: tb/beep_tone_gen_tb.sv
module beep_tone_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        tick_48k = 1'b0;
  logic        ext_beep = 1'b0;
  logic        in_reset_state = 1'b0;
  logic [15:0] rd_data;
  logic        beep_out, mute_out;
  logic [3:0]  atten_code;

  int tests = 0, fails = 0;
  string cur_req = "R1";

  // behavioural reference
  int  m_f = 0, m_pv = 0, m_cnt = 0;
  bit  m_mute = 1, m_tone = 0;

  always #5 clk = ~clk;

  beep_tone_gen u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .tick_48k(tick_48k), .ext_beep(ext_beep), .in_reset_state(in_reset_state),
    .beep_out(beep_out), .atten_code(atten_code), .mute_out(mute_out)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      int nf;
      nf = int'(wr_data[12:5]);
      if (wr_en && nf != m_f) begin
        m_f = nf; m_mute = wr_data[15]; m_pv = int'(wr_data[4:1]);
        m_cnt = 0; m_tone = 0;
      end else begin
        if (wr_en) begin m_mute = wr_data[15]; m_pv = int'(wr_data[4:1]); end
        if (m_f == 0) begin m_cnt = 0; m_tone = 0; end
        else if (tick_48k) begin
          if (m_cnt == 2*m_f - 1) begin m_cnt = 0; m_tone = !m_tone; end
          else m_cnt++;
        end
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    int exp_rd;
    bit exp_beep;
    exp_rd = (int'(m_mute) << 15) | (m_f << 5) | (m_pv << 1);
    exp_beep = (in_reset_state || m_f == 0) ? ext_beep : m_tone;
    check(cur_req, "rd_data", int'(rd_data), exp_rd);
    check(cur_req, "beep_out", int'(beep_out), int'(exp_beep));
    check(cur_req, "atten_code", int'(atten_code), in_reset_state ? 0 : m_pv);
    check(cur_req, "mute_out", int'(mute_out), in_reset_state ? 0 : int'(m_mute));
  endtask

  task automatic step(bit wr, logic [15:0] d, bit tk, bit ext, bit inr);
    @(negedge clk);
    compare();
    wr_en = wr; wr_data = d; tick_48k = tk; ext_beep = ext; in_reset_state = inr;
  endtask

  function automatic logic [15:0] word(bit mu, int f, int pv, logic [2:0] junk);
    return {mu, junk[2:1], 8'(f), 4'(pv), junk[0]};
  endfunction

  task automatic run(int n, int tick_every);
    for (int i = 0; i < n; i++) step(0, '0, (i % tick_every) == 0, 0, 0);
  endtask

  initial begin
    #2_000_000;
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    check("R1", "reset rd_data", int'(rd_data), 16'h8000);
    check("R1", "reset mute_out", int'(mute_out), 1);

    cur_req = "R2";   // junk in unused bits 14:13 and 0 must read 0
    step(1, word(0, 1, 5, 3'b111), 0, 0, 0);
    step(0, '0, 0, 0, 0);
    step(1, word(1, 1, 15, 3'b101), 0, 0, 0);
    step(0, '0, 0, 0, 0);

    cur_req = "R4";   // F=1: 12 kHz, strobe every cycle
    step(1, word(0, 1, 0, 3'b000), 0, 0, 0);
    run(40, 1);
    cur_req = "R5";   // sparse strobes
    step(1, word(0, 3, 9, 3'b000), 0, 0, 0);
    run(90, 4);
    cur_req = "R7";   // same-F write mid-tone, with strobe in that cycle
    step(1, word(1, 3, 2, 3'b000), 1, 0, 0);
    run(20, 1);
    step(1, word(1, 7, 2, 3'b000), 1, 0, 0);   // F changes, strobe ignored
    run(70, 1);
    step(1, word(0, 2, 2, 3'b000), 1, 0, 0);
    run(30, 2);

    cur_req = "R6";   // bypass to external input
    step(1, word(0, 0, 4, 3'b000), 1, 0, 0);
    for (int i = 0; i < 24; i++) step(0, '0, i[0], i[1] ^ i[3], 0);

    cur_req = "R8";   // reset-state override, with tone running and muted
    step(1, word(1, 2, 12, 3'b000), 1, 0, 0);
    for (int i = 0; i < 30; i++) step(0, '0, 1, i[2], i > 5 && i < 25);

    cur_req = "R3";
    for (int p = 0; p < 16; p++) step(1, word(p[0], 4, p, 3'b000), 1, 0, 0);

    cur_req = "R4";   // F=255: about 47 Hz, two full periods
    step(1, word(0, 255, 0, 3'b000), 0, 0, 0);
    run(2100, 1);

    step(0, '0, 0, 0, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule